// File: doc/BRIEF.md
# Multi-Sequencer ADC Sample Controller

This block schedules conversions on one external analog-to-digital converter for four independent sample sequencers. Each sequencer holds a short program of steps. Each step names an input channel and carries a 4-bit control nibble, and the program stops at the step flagged as final. Software starts a sequencer by writing a kick register. When more than one sequencer is waiting, a programmable priority word decides which one runs next. A run is never interrupted once it has started.

Each conversion result goes into a small FIFO that belongs to the sequencer that asked for it. Software pops the FIFO through a data register. Raw completion status, the interrupt mask and the masked view are held apart. Overflow and underflow are recorded per sequencer and cleared by writing 1.

The register bus is word addressed. The write takes effect at the clock edge where `bus_wr` is high. Read data is registered and appears one cycle after `bus_rd`. Global registers: 0x00 enable, 0x01 raw status, 0x02 mask, 0x03 masked status, 0x04 overflow, 0x05 underflow, 0x06 priority, 0x07 kick. Sequencer n owns 0x10+4n (channel word), 0x11+4n (control word), 0x12+4n (FIFO data) and 0x13+4n (FIFO status).

Top module: `adc_seq_ctrl`

## Requirements
- R1: In the control word, step k owns bits [4k+3:4k]. Bit 1 of that nibble ends the run after step k converts. Bit 2 of that nibble sets raw status bit n of the sequencer when the run completes.
- R2: In the channel word, step k owns bits [4k+3:4k]. Each step issues a one-cycle `conv_start` with that channel on `conv_chan`. Steps go out in ascending order, and the next start comes only after `conv_done` for the previous step.
- R3: Sequencer 0 holds up to 8 steps and sequencers 1 to 3 hold up to 4. A program with no end flag finishes after its last physical step.
- R4: All enable bits (register 0x00, bit n) reset to 0. A kick to a disabled sequencer is dropped and is not retained when the sequencer is enabled later.
- R5: The priority register resets to 0x3210. Sequencer n has a 2-bit field at bits [4n+1:4n], and the lowest value wins. On equal values the lower index wins.
- R6: Arbitration happens only between runs. A sequencer kicked during another run waits until that run has finished, whatever its priority.
- R7: Raw status (0x01) ignores writes. `irq[n]` follows raw AND mask one cycle later. Register 0x03 reads raw AND mask, and writing 1 to a bit there clears that raw bit.
- R8: Each result is pushed into its sequencer's 4-entry FIFO. A read of the data register pops one entry, with the result in bits [9:0]. The status register reads the count in [3:0], empty at bit 8 and full at bit 12, and resets to 0x100.
- R9: A result that arrives at a full FIFO is discarded and sets overflow bit n (0x04). Writing 1 to that bit clears it.
- R10: A data read from an empty FIFO returns 0 and sets underflow bit n (0x05). Writing 1 to that bit clears it.
- R11: A write to register 0x07 sets a run request for sequencer n for each bit n written as 1. The register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the requested conversion |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 10 | Converter result |
| irq | output | 4 | Per-sequencer interrupt |

## Verification
Most faults in the step counter or in the channel lookup show up on the very next `conv_start`, as a channel out of order, an extra start or a missing one. The scoreboard compares every start against the queued program. A wrong arbitration choice or a wrong priority field shows up as the wrong first channel after a kick. A FIFO pointer or count fault shows up at the next status read or data pop, as a wrong count, a wrong value, or overflow or underflow bits that stay clear. Status and mask mistakes reach `irq` one cycle after a run ends and are checked a few cycles later.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NSEQ   = 4;
  localparam int PRIO_W = 2;
  localparam int CTL_W  = 4;

  localparam int CTL_END_BIT = 1;
  localparam int CTL_IE_BIT  = 2;

  localparam logic [5:0] A_EN    = 6'h00;
  localparam logic [5:0] A_RAW   = 6'h01;
  localparam logic [5:0] A_MASK  = 6'h02;
  localparam logic [5:0] A_ISTAT = 6'h03;
  localparam logic [5:0] A_OVF   = 6'h04;
  localparam logic [5:0] A_UNF   = 6'h05;
  localparam logic [5:0] A_PRIO  = 6'h06;
  localparam logic [5:0] A_KICK  = 6'h07;
  localparam logic [5:0] A_SEQ   = 6'h10;

  typedef enum logic [1:0] {F_MUX = 2'd0, F_CTL = 2'd1, F_DATA = 2'd2, F_STAT = 2'd3} seq_field_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} eng_state_e;
endpackage

// File: rtl/adc_seq_arb.sv
module adc_seq_arb
  import adc_seq_pkg::*;
#(
  parameter int N = NSEQ,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]        req,
  input  logic [PRIO_W-1:0]   prio [N],
  output logic                win_valid,
  output logic [SW-1:0]       win_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!win_valid || prio[i] < best)) begin
        win_valid = 1'b1;
        win_idx   = SW'(i);
        best      = prio[i];
      end
    end
  end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int N      = NSEQ,
  parameter int STEPS0 = 8,
  parameter int STEPSN = 4,
  parameter int CHAN_W = 4,
  localparam int MAXSTEPS = (STEPS0 > STEPSN) ? STEPS0 : STEPSN,
  localparam int MW = MAXSTEPS * CHAN_W,
  localparam int CW = MAXSTEPS * CTL_W,
  localparam int SW = $clog2(N),
  localparam int TW = $clog2(MAXSTEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [SW-1:0]     win_idx,
  input  logic [MW-1:0]     mux_w [N],
  input  logic [CW-1:0]     ctl_w [N],
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [N-1:0]      grant,
  output logic              push,
  output logic [N-1:0]      ie_set,
  output logic [SW-1:0]     cur_seq,
  output logic [TW-1:0]     cur_step
);
  eng_state_e        state;
  logic [CTL_W-1:0]  cur_ctl;
  logic              at_last, is_end;
  logic [TW-1:0]     nxt_step;

  function automatic logic [TW-1:0] last_of(input logic [SW-1:0] s);
    return (s == '0) ? TW'(STEPS0 - 1) : TW'(STEPSN - 1);
  endfunction

  always_comb begin
    cur_ctl  = ctl_w[cur_seq][int'(cur_step) * CTL_W +: CTL_W];
    at_last  = (cur_step == last_of(cur_seq));
    is_end   = cur_ctl[CTL_END_BIT] || at_last;
    nxt_step = cur_step + 1'b1;
    push     = (state == ST_WAIT) && !conv_start && conv_done;
    grant    = '0;
    if (state == ST_IDLE && win_valid) grant[win_idx] = 1'b1;
    ie_set   = '0;
    if (push && is_end && cur_ctl[CTL_IE_BIT]) ie_set[cur_seq] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_seq    <= '0;
      cur_step   <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          conv_start <= 1'b0;
          if (win_valid) begin
            cur_seq    <= win_idx;
            cur_step   <= '0;
            conv_start <= 1'b1;
            conv_chan  <= mux_w[win_idx][CHAN_W-1:0];
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          conv_start <= 1'b0;
          if (push) begin
            if (is_end) begin
              state <= ST_IDLE;
            end else begin
              cur_step   <= nxt_step;
              conv_start <= 1'b1;
              conv_chan  <= mux_w[cur_seq][int'(nxt_step) * CHAN_W +: CHAN_W];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STEPS0     = 8,
  parameter int STEPSN     = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 10,
  parameter int CHAN_W     = 4,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [NSEQ-1:0]   irq
);
  localparam int MAXSTEPS = (STEPS0 > STEPSN) ? STEPS0 : STEPSN;
  localparam int MW       = MAXSTEPS * CHAN_W;
  localparam int CW       = MAXSTEPS * CTL_W;
  localparam int SW       = $clog2(NSEQ);
  localparam int TW       = $clog2(MAXSTEPS);
  localparam int NW       = $clog2(FIFO_DEPTH + 1);

  logic [NSEQ-1:0]   en_q, mask_q, raw_q, ovf_q, unf_q, pend_q;
  logic [PRIO_W-1:0] prio_q [NSEQ];
  logic [MW-1:0]     mux_q  [NSEQ];
  logic [CW-1:0]     ctl_q  [NSEQ];

  logic              win_valid, eng_push;
  logic [SW-1:0]     win_idx, eng_cur;
  logic [TW-1:0]     eng_step;
  logic [NSEQ-1:0]   grant, ie_set;

  logic [DATA_W-1:0] f_head [NSEQ];
  logic [NW-1:0]     f_cnt  [NSEQ];
  logic [NSEQ-1:0]   f_empty, f_full, f_push, f_pop;
  logic [NSEQ-1:0]   ovf_set, unf_set, kick;

  logic              seq_area;
  logic [SW-1:0]     sel_seq;
  seq_field_e        sel_fld;
  logic [ADDR_W-1:0] seq_off;
  logic [31:0]       rd_val;

  function automatic logic [MW-1:0] mux_mask(input int s);
    return {MW{1'b1}} >> (((s == 0) ? (MAXSTEPS - STEPS0) : (MAXSTEPS - STEPSN)) * CHAN_W);
  endfunction

  function automatic logic [CW-1:0] ctl_mask(input int s);
    return {CW{1'b1}} >> (((s == 0) ? (MAXSTEPS - STEPS0) : (MAXSTEPS - STEPSN)) * CTL_W);
  endfunction

  // address decode
  always_comb begin
    seq_off  = bus_addr - ADDR_W'(A_SEQ);
    seq_area = (bus_addr >= ADDR_W'(A_SEQ)) && (bus_addr < ADDR_W'(A_SEQ) + ADDR_W'(4 * NSEQ));
    sel_seq  = seq_off[SW+1:2];
    sel_fld  = seq_field_e'(seq_off[1:0]);
  end

  adc_seq_arb #(.N(NSEQ)) u_arb (
    .req       (pend_q),
    .prio      (prio_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  adc_seq_engine #(
    .N(NSEQ), .STEPS0(STEPS0), .STEPSN(STEPSN), .CHAN_W(CHAN_W)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .mux_w      (mux_q),
    .ctl_w      (ctl_q),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .grant      (grant),
    .push       (eng_push),
    .ie_set     (ie_set),
    .cur_seq    (eng_cur),
    .cur_step   (eng_step)
  );

  for (genvar n = 0; n < NSEQ; n++) begin : g_fifo
    always_comb begin
      f_push[n]  = eng_push && (eng_cur == SW'(n)) && !f_full[n];
      ovf_set[n] = eng_push && (eng_cur == SW'(n)) && f_full[n];
      f_pop[n]   = bus_rd && seq_area && (sel_seq == SW'(n)) && (sel_fld == F_DATA) && !f_empty[n];
      unf_set[n] = bus_rd && seq_area && (sel_seq == SW'(n)) && (sel_fld == F_DATA) && f_empty[n];
    end

    adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (f_push[n]),
      .din   (conv_data),
      .pop   (f_pop[n]),
      .head  (f_head[n]),
      .count (f_cnt[n]),
      .empty (f_empty[n]),
      .full  (f_full[n])
    );
  end

  assign kick = (bus_wr && bus_addr == ADDR_W'(A_KICK)) ? bus_wdata[NSEQ-1:0] : '0;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      raw_q  <= '0;
      ovf_q  <= '0;
      unf_q  <= '0;
      pend_q <= '0;
      irq    <= '0;
      for (int n = 0; n < NSEQ; n++) begin
        prio_q[n] <= PRIO_W'(n);
        mux_q[n]  <= '0;
        ctl_q[n]  <= '0;
      end
    end else begin
      pend_q <= ((pend_q & ~grant) | kick) & en_q;
      irq    <= raw_q & mask_q;
      raw_q  <= (raw_q & ~((bus_wr && bus_addr == ADDR_W'(A_ISTAT)) ? bus_wdata[NSEQ-1:0] : '0)) | ie_set;
      ovf_q  <= (ovf_q & ~((bus_wr && bus_addr == ADDR_W'(A_OVF)) ? bus_wdata[NSEQ-1:0] : '0)) | ovf_set;
      unf_q  <= (unf_q & ~((bus_wr && bus_addr == ADDR_W'(A_UNF)) ? bus_wdata[NSEQ-1:0] : '0)) | unf_set;
      if (bus_wr) begin
        if (bus_addr == ADDR_W'(A_EN))   en_q   <= bus_wdata[NSEQ-1:0];
        if (bus_addr == ADDR_W'(A_MASK)) mask_q <= bus_wdata[NSEQ-1:0];
        if (bus_addr == ADDR_W'(A_PRIO)) begin
          for (int n = 0; n < NSEQ; n++) prio_q[n] <= bus_wdata[4*n +: PRIO_W];
        end
        for (int n = 0; n < NSEQ; n++) begin
          if (seq_area && sel_seq == SW'(n) && sel_fld == F_MUX) mux_q[n] <= bus_wdata[MW-1:0] & mux_mask(n);
          if (seq_area && sel_seq == SW'(n) && sel_fld == F_CTL) ctl_q[n] <= bus_wdata[CW-1:0] & ctl_mask(n);
        end
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (seq_area) begin
      case (sel_fld)
        F_MUX:  rd_val = 32'(mux_q[sel_seq]);
        F_CTL:  rd_val = 32'(ctl_q[sel_seq]);
        F_DATA: rd_val = f_empty[sel_seq] ? 32'd0 : 32'(f_head[sel_seq]);
        F_STAT: rd_val = 32'(f_cnt[sel_seq]) | (32'(f_empty[sel_seq]) << 8) | (32'(f_full[sel_seq]) << 12);
        default: rd_val = '0;
      endcase
    end else begin
      case (bus_addr)
        ADDR_W'(A_EN):    rd_val = 32'(en_q);
        ADDR_W'(A_RAW):   rd_val = 32'(raw_q);
        ADDR_W'(A_MASK):  rd_val = 32'(mask_q);
        ADDR_W'(A_ISTAT): rd_val = 32'(raw_q & mask_q);
        ADDR_W'(A_OVF):   rd_val = 32'(ovf_q);
        ADDR_W'(A_UNF):   rd_val = 32'(unf_q);
        ADDR_W'(A_PRIO): begin
          for (int n = 0; n < NSEQ; n++) rd_val[4*n +: PRIO_W] = prio_q[n];
        end
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_start,
  input logic          conv_done,
  input logic          bus_rd,
  input logic [N-1:0]  irq,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  en,
  input logic [N-1:0]  ovf,
  input logic [N-1:0]  unf,
  input logic [SW-1:0] cur_seq,
  input logic [TW-1:0] cur_step
);
  logic [N-1:0] en_d;
  always_ff @(posedge clk) begin
    if (rst) en_d <= '0;
    else     en_d <= en;
  end

  a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r4_start_enabled: assert property (@(posedge clk) disable iff (rst)
    (conv_start && cur_step == '0) |-> en_d[cur_seq]);

  for (genvar i = 0; i < N; i++) begin : g_bit
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(mask[i]));
    a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf[i]) |-> $past(conv_done));
    a_r10_unf_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(unf[i]) |-> $past(bus_rd));
  end
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.N(NSEQ), .SW(SW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .bus_rd     (bus_rd),
  .irq        (irq),
  .mask       (mask_q),
  .en         (en_q),
  .ovf        (ovf_q),
  .unf        (unf_q),
  .cur_seq    (eng_cur),
  .cur_step   (eng_step)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [3:0]  irq;

  int checks = 0, errors = 0;
  int exp_q[$];
  logic [31:0] rv;

  always #2 clk = ~clk;

  adc_seq_ctrl uut (.*);

  function automatic logic [9:0] cv(input int ch);
    return 10'((ch * 37 + 5) & 10'h3ff);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R2 all expected conversions issued", 32'(exp_q.size()), 32'd0);
  endtask

  // converter model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (!rst && conv_start) begin
        int ch;
        ch = int'(conv_chan);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2/R4: unexpected start, actual chan %0d expected none", ch);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != ch) begin
            errors++;
            $display("FAIL R2/R5/R6: actual chan %0d expected %0d", ch, e);
          end
        end
        repeat (2) @(negedge clk);
        conv_data = cv(ch);
        conv_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R7 irq reset", 32'(irq), 0);
    rd(6'h00, rv); chk("R4 enable reset", rv, 0);
    rd(6'h06, rv); chk("R5 priority reset", rv, 32'h3210);
    rd(6'h13, rv); chk("R8 fifo0 status reset", rv, 32'h100);

    // basic 3-step run on sequencer 0 with end + interrupt on step 2
    wr(6'h10, 32'h173);
    wr(6'h11, 32'h600);
    wr(6'h02, 32'h1);
    wr(6'h00, 32'h1);
    exp_q.push_back(3); exp_q.push_back(7); exp_q.push_back(1);
    wr(6'h07, 32'h1);
    wait_idle();
    chk("R1 R7 irq after end step", 32'(irq), 32'h1);
    rd(6'h01, rv); chk("R1 raw status", rv, 32'h1);
    wr(6'h01, 32'hF);
    rd(6'h01, rv); chk("R7 raw ignores writes", rv, 32'h1);
    rd(6'h03, rv); chk("R7 masked status", rv, 32'h1);
    rd(6'h07, rv); chk("R11 kick reads zero", rv, 0);
    rd(6'h13, rv); chk("R8 fifo0 count 3", rv, 32'h3);
    rd(6'h12, rv); chk("R8 pop 1", rv, 32'(cv(3)));
    rd(6'h12, rv); chk("R8 pop 2", rv, 32'(cv(7)));
    rd(6'h12, rv); chk("R8 pop 3", rv, 32'(cv(1)));
    rd(6'h12, rv); chk("R10 empty read returns 0", rv, 0);
    rd(6'h05, rv); chk("R10 underflow set", rv, 32'h1);
    wr(6'h05, 32'h1);
    rd(6'h05, rv); chk("R10 underflow cleared", rv, 0);
    wr(6'h03, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 irq cleared by w1c", 32'(irq), 0);

    // priority: sequencer 2 ahead of 1
    wr(6'h14, 32'h5); wr(6'h15, 32'h2);
    wr(6'h18, 32'h9); wr(6'h19, 32'h6);
    wr(6'h06, 32'h2013);
    wr(6'h00, 32'h7);
    exp_q.push_back(9); exp_q.push_back(5);
    wr(6'h07, 32'h6);
    wait_idle();
    rd(6'h01, rv); chk("R1 raw only for IE step", rv, 32'h4);
    chk("R7 unmasked raw keeps irq low", 32'(irq), 0);
    wr(6'h02, 32'h4);
    repeat (3) @(negedge clk);
    chk("R7 irq follows mask", 32'(irq), 32'h4);
    wr(6'h03, 32'h4);
    repeat (3) @(negedge clk);
    chk("R7 irq2 cleared", 32'(irq), 0);

    // equal priority: lower index wins
    wr(6'h06, 32'h3113);
    rd(6'h06, rv); chk("R5 priority readback", rv, 32'h3113);
    exp_q.push_back(5); exp_q.push_back(9);
    wr(6'h07, 32'h6);
    wait_idle();
    rd(6'h17, rv); chk("R8 fifo1 count 2", rv, 32'h2);
    rd(6'h16, rv); chk("R8 fifo1 pop", rv, 32'(cv(5)));

    // disabled sequencer ignores kick
    wr(6'h1C, 32'h4); wr(6'h1D, 32'h2);
    wr(6'h07, 32'h8);
    repeat (30) @(negedge clk);
    wr(6'h00, 32'hF);
    repeat (30) @(negedge clk);
    rd(6'h1F, rv); chk("R4 disabled kick dropped", rv, 32'h100);
    wr(6'h00, 32'h7);

    // overflow: 5 steps into 4-entry fifo
    wr(6'h10, 32'h54321);
    wr(6'h11, 32'h20000);
    for (int c = 1; c <= 5; c++) exp_q.push_back(c);
    wr(6'h07, 32'h1);
    wait_idle();
    rd(6'h04, rv); chk("R9 overflow set", rv, 32'h1);
    rd(6'h13, rv); chk("R8 R9 fifo0 full", rv, 32'h1004);
    for (int c = 1; c <= 4; c++) begin
      rd(6'h12, rv); chk("R9 kept entries", rv, 32'(cv(c)));
    end
    wr(6'h04, 32'h1);
    rd(6'h04, rv); chk("R9 overflow cleared", rv, 0);

    // no end flag: 8 steps, and no preemption by a higher-priority kick
    wr(6'h10, 32'hFEDCBA98);
    wr(6'h11, 32'h0);
    wr(6'h06, 32'h3013);
    for (int c = 8; c <= 15; c++) exp_q.push_back(c);
    exp_q.push_back(9);
    wr(6'h07, 32'h1);
    for (int i = 0; i < 100 && exp_q.size() > 8; i++) @(negedge clk);
    wr(6'h07, 32'h4);
    wait_idle();
    rd(6'h13, rv); chk("R3 eight-step run filled fifo0", rv, 32'h1004);
    rd(6'h04, rv); chk("R3 R9 extra steps overflowed", rv, 32'h1);
    rd(6'h1B, rv); chk("R6 seq2 ran after seq0", rv, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule